// File: doc/BRIEF.md
# Two-Wire Strobe/Acknowledge Parallel Byte Port

This block moves 8-bit bytes between an on-chip core and an external peripheral over a parallel bus with two control lines. One line is a data-available strobe, active low. The other is a ready/acknowledge line, which is high when the receiving side can accept a byte. Each edge on one line waits for a matching edge on the other line. The two lines swap owners with the direction of transfer.

In receive mode the peripheral drives the strobe and the port drives the ready line. The port captures the bus when the strobe falls and pulls ready low as an acknowledge. Ready stays low until two things are true: the strobe has gone high again, and the core has taken the byte. This gives back-pressure toward the peripheral.

In send mode the roles swap. The core hands over a byte, and the port drives it onto the bus. One clock later the port lowers the strobe. The strobe stays low until the peripheral pulls ready low, and then it goes high. The port does not start another byte until ready is high again.

Both incoming control lines pass through a synchroniser before any decision is made. A single-cycle `done` pulse marks each byte received or sent. The direction request is applied only while the handshake is idle.

Top module: `strobe_port`

## Requirements
- R1: While reset is applied and after it is released, the port is in receive mode with idle lines: `pin_oe`=0, `rdy_out`=1, `dav_out`=1, `rx_valid`=0, `tx_ready`=0 and `done`=0.
- R2: In receive mode, a fall of `dav_in` captures `pin_data_in` into `rx_data` and sets `rx_valid`. `rdy_out` goes low on the third rising clock edge after the fall, and no sooner, because of a two-stage synchroniser plus one decision register.
- R3: In receive mode, `rdy_out` stays low until `dav_in` has gone high and the core has taken the byte (`rx_valid`=1 and `rx_ready`=1 on a clock edge). It goes high on the second edge after the take, or on the third edge after the `dav_in` rise if that rise comes later.
- R4: While a byte is held (`rx_valid`=1 and `rx_ready`=0), `rx_data` does not change. A further fall of `dav_in` while `rdy_out` is low captures nothing.
- R5: In send mode, a byte accepted on `tx_valid`/`tx_ready` appears on `pin_data_out` after the accepting edge while `dav_out` is still high. `dav_out` falls one clock later, and the bus is held unchanged during the strobe.
- R6: In send mode, `dav_out` stays low while `rdy_in` is high. It rises on the third rising edge after `rdy_in` falls.
- R7: In send mode, `tx_ready` is high only when the port is idle and the synchronised `rdy_in` is high. After a byte, `tx_ready` returns on the third edge after `rdy_in` rises.
- R8: `done` is a one-cycle pulse. It is raised together with the capture in receive mode, and together with the `dav_out` rise in send mode.
- R9: `out_mode_req` (1 = send, 0 = receive) takes effect only while both handshakes are idle. `pin_oe` reports the active mode. In send mode `rdy_out` is held high and `dav_in` is ignored. In receive mode `dav_out` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| out_mode_req | input | 1 | Requested direction: 1 send, 0 receive |
| pin_data_in | input | 8 | Parallel bus sampled in receive mode |
| pin_data_out | output | 8 | Parallel bus value driven in send mode |
| pin_oe | output | 1 | Bus output enable; high in send mode |
| dav_in | input | 1 | Peripheral strobe, active low (receive mode) |
| dav_out | output | 1 | Port strobe, active low (send mode) |
| rdy_in | input | 1 | Peripheral ready/acknowledge (send mode) |
| rdy_out | output | 1 | Port ready/acknowledge (receive mode) |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte is available |
| rx_ready | input | 1 | Core takes the received byte |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Core offers a byte to send |
| tx_ready | output | 1 | Port accepts a byte to send |
| done | output | 1 | One-cycle pulse per byte received or sent |

## Verification
All 256 byte values are sent through each direction, so a stuck, swapped or shifted data bit shows up on at least one byte.

Receive-mode bytes rotate the core's take delay through 0 to 3 cycles. This separates the case where the strobe rise releases ready from the case where the core take releases it, each with its own exact edge count.

Send-mode bytes rotate the peripheral's acknowledge delay, which shows that the strobe is held for as long as ready stays high. Separate patterns cover three cases: a second strobe fall while a byte is still held, a direction request made mid-transfer, and strobe activity in the wrong mode. These separate real interlocking from behaviour that only looks correct for well-behaved peripherals.

// File: rtl/strobe_port_pkg.sv
package strobe_port_pkg;

  typedef enum logic [0:0] {
    RX_IDLE = 1'b0,
    RX_HOLD = 1'b1
  } rx_state_e;

  typedef enum logic [1:0] {
    TX_IDLE    = 2'd0,
    TX_SETUP   = 2'd1,
    TX_STROBE  = 2'd2,
    TX_RELEASE = 2'd3
  } tx_state_e;

endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] st_d;

  always_comb begin
    st_d = {st_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= {STAGES{RST_VAL}};
    else        st_q <= st_d;
  end

  assign q = st_q[LAST];
endmodule

// File: rtl/sp_rx_engine.sv
module sp_rx_engine import strobe_port_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              dav_s,
  input  logic [DATA_W-1:0] pin_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rdy_o,
  output logic              got_o
);
  rx_state_e         state_q, state_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              vld_q, vld_d;
  logic              got, take;

  // HOLD is only left when the strobe is high, so a low strobe seen in IDLE is a new fall
  always_comb begin
    got     = en && (state_q == RX_IDLE) && !dav_s;
    take    = vld_q && rx_ready;
    state_d = state_q;
    data_d  = data_q;
    vld_d   = vld_q;
    if (take) vld_d = 1'b0;
    if (got) begin
      vld_d  = 1'b1;
      data_d = pin_data;
    end
    case (state_q)
      RX_IDLE: if (got) state_d = RX_HOLD;
      RX_HOLD: if (dav_s && !vld_q) state_d = RX_IDLE;
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      vld_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      vld_q   <= vld_d;
      if (got) data_q <= data_d;
    end
  end

  assign rx_data  = data_q;
  assign rx_valid = vld_q;
  assign rdy_o    = (state_q == RX_IDLE);
  assign got_o    = got;
endmodule

// File: rtl/sp_tx_engine.sv
module sp_tx_engine import strobe_port_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rdy_s,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] pin_data,
  output logic              dav_o,
  output logic              idle_o,
  output logic              sent_o
);
  tx_state_e         state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic              accept, sent;

  always_comb begin
    tx_ready = en && (state_q == TX_IDLE) && rdy_s;
    accept   = tx_ready && tx_valid;
    sent     = (state_q == TX_STROBE) && !rdy_s;
    state_d  = state_q;
    case (state_q)
      TX_IDLE:    if (accept) state_d = TX_SETUP;
      TX_SETUP:   state_d = TX_STROBE;
      TX_STROBE:  if (!rdy_s) state_d = TX_RELEASE;
      TX_RELEASE: if (rdy_s) state_d = TX_IDLE;
      default:    state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) data_q <= tx_data;
    end
  end

  assign pin_data = data_q;
  assign dav_o    = (state_q != TX_STROBE);
  assign idle_o   = (state_q == TX_IDLE);
  assign sent_o   = sent;
endmodule

// File: rtl/strobe_port.sv
module strobe_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_mode_req,
  input  logic [DATA_W-1:0] pin_data_in,
  output logic [DATA_W-1:0] pin_data_out,
  output logic              pin_oe,
  input  logic              dav_in,
  output logic              dav_out,
  input  logic              rdy_in,
  output logic              rdy_out,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              done
);
  logic core_rst_n;
  logic dav_s, rdy_s;
  logic dir_q, dir_d, dir_en;
  logic done_q, done_d;
  logic rx_rdy, rx_got;
  logic tx_dav, tx_idle, tx_sent;

  // reset: asserted at once, released after SYNC_STAGES edges
  sp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(core_rst_n));

  sp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dav_sync (
    .clk(clk), .rst_n(core_rst_n), .d(dav_in), .q(dav_s));

  sp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
    .clk(clk), .rst_n(core_rst_n), .d(rdy_in), .q(rdy_s));

  sp_rx_engine #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(core_rst_n), .en(!dir_q), .dav_s(dav_s),
    .pin_data(pin_data_in), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rdy_o(rx_rdy), .got_o(rx_got));

  sp_tx_engine #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(core_rst_n), .en(dir_q), .rdy_s(rdy_s),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .pin_data(pin_data_out), .dav_o(tx_dav), .idle_o(tx_idle),
    .sent_o(tx_sent));

  // direction changes only while neither handshake is in progress
  always_comb begin
    dir_en = rx_rdy && !rx_valid && tx_idle;
    dir_d  = out_mode_req;
    done_d = rx_got || tx_sent;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      dir_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (dir_en) dir_q <= dir_d;
      done_q <= done_d;
    end
  end

  assign pin_oe  = dir_q;
  assign rdy_out = rx_rdy;
  assign dav_out = tx_dav;
  assign done    = done_q;
endmodule

// File: rtl/strobe_port_chk.sv
module strobe_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] pin_data_out,
  input logic              pin_oe,
  input logic              dav_out,
  input logic              rdy_in,
  input logic              rdy_out,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_ready,
  input logic              done
);
  // R2
  capture_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rdy_out) && !pin_oe) |-> (rx_valid && done));

  // R3
  held_byte_blocks_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !pin_oe) |-> !rdy_out);

  // R4
  held_byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R5
  bus_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && $fell(dav_out)) |-> ($stable(pin_data_out) && $past(pin_oe)));

  // R6
  strobe_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && !dav_out && $past(rdy_in, 2)) |=> !dav_out);

  // R7
  ready_needs_peer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> $past(rdy_in, 2));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe ? rdy_out : dav_out));
endmodule

bind strobe_port strobe_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_data_out(pin_data_out), .pin_oe(pin_oe),
  .dav_out(dav_out), .rdy_in(rdy_in), .rdy_out(rdy_out), .rx_data(rx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_ready(tx_ready), .done(done));

// File: tb/strobe_port_bench.sv
module strobe_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, out_mode_req, dav_in, rdy_in, rx_ready, tx_valid;
  logic [7:0] pin_data_in, tx_data;
  logic [7:0] pin_data_out, rx_data;
  logic       pin_oe, dav_out, rdy_out, rx_valid, tx_ready, done;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_port u_strobe_port (
    .clk(clk), .rst_n(rst_n), .out_mode_req(out_mode_req),
    .pin_data_in(pin_data_in), .pin_data_out(pin_data_out), .pin_oe(pin_oe),
    .dav_in(dav_in), .dav_out(dav_out), .rdy_in(rdy_in), .rdy_out(rdy_out),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // receive one byte; core takes it k cycles after the capture
  task automatic in_xfer(input logic [7:0] b, input int k);
    int rel;
    @(negedge clk);
    pin_data_in = b;
    dav_in      = 1'b0;
    repeat (2) @(negedge clk);
    chk(rdy_out == 1'b1, "R2 rdy still high before sync", rdy_out, 1);
    @(negedge clk);
    chk(rdy_out == 1'b0, "R2 rdy low on third edge", rdy_out, 0);
    chk(rx_valid == 1'b1, "R2 rx_valid", rx_valid, 1);
    chk(rx_data == b, "R2 captured byte", rx_data, b);
    chk(done == 1'b1, "R8 done on capture", done, 1);
    dav_in      = 1'b1;
    pin_data_in = ~b;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (i == 0) chk(done == 1'b0, "R8 done one cycle", done, 0);
      chk(rdy_out == 1'b0, "R3 rdy low while byte held", rdy_out, 0);
      chk(rx_data == b, "R4 held byte stable", rx_data, b);
    end
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(rx_valid == 1'b0, "R3 byte taken", rx_valid, 0);
    if (k == 0) chk(done == 1'b0, "R8 done one cycle", done, 0);
    rel = (k == 0) ? 3 : 2;
    for (int i = 1; i < rel; i++) begin
      chk(rdy_out == 1'b0, "R3 rdy not yet released", rdy_out, 0);
      @(negedge clk);
    end
    chk(rdy_out == 1'b1, "R3 rdy released", rdy_out, 1);
  endtask

  // send one byte; peripheral acknowledges k cycles after the strobe
  task automatic out_xfer(input logic [7:0] b, input int k);
    int t = 0;
    while (!tx_ready && t < 20) begin
      @(negedge clk);
      t++;
    end
    chk(tx_ready == 1'b1, "R7 tx_ready when idle", tx_ready, 1);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data  = ~b;
    chk(pin_data_out == b, "R5 bus driven", pin_data_out, b);
    chk(dav_out == 1'b1, "R5 strobe waits one clock", dav_out, 1);
    chk(tx_ready == 1'b0, "R7 busy", tx_ready, 0);
    @(negedge clk);
    chk(dav_out == 1'b0, "R5 strobe low", dav_out, 0);
    chk(pin_data_out == b, "R5 bus held", pin_data_out, b);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      chk(dav_out == 1'b0, "R6 strobe held until ack", dav_out, 0);
    end
    rdy_in = 1'b0;
    repeat (2) @(negedge clk);
    chk(dav_out == 1'b0, "R6 strobe low before sync", dav_out, 0);
    @(negedge clk);
    chk(dav_out == 1'b1, "R6 strobe raised", dav_out, 1);
    chk(done == 1'b1, "R8 done on send", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
    chk(tx_ready == 1'b0, "R7 no ready while ack low", tx_ready, 0);
    rdy_in = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_ready == 1'b0, "R7 ready waits for sync", tx_ready, 0);
    chk(dav_out == 1'b1, "R7 no new strobe", dav_out, 1);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R7 ready back", tx_ready, 1);
  endtask

  initial begin
    rst_n = 1'b0; out_mode_req = 1'b0; dav_in = 1'b1; rdy_in = 1'b1;
    rx_ready = 1'b0; tx_valid = 1'b0; pin_data_in = '0; tx_data = '0;
    repeat (3) @(negedge clk);
    chk(rdy_out == 1'b1 && dav_out == 1'b1, "R1 lines idle in reset", {rdy_out, dav_out}, 3);
    chk(pin_oe == 1'b0, "R1 receive mode in reset", pin_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pin_oe == 1'b0, "R1 receive mode", pin_oe, 0);
    chk(rdy_out == 1'b1, "R1 rdy high", rdy_out, 1);
    chk(dav_out == 1'b1, "R1 dav high", dav_out, 1);
    chk(rx_valid == 1'b0, "R1 no byte", rx_valid, 0);
    chk(tx_ready == 1'b0, "R1 tx_ready low", tx_ready, 0);
    chk(done == 1'b0, "R1 done low", done, 0);

    for (int b = 0; b < 256; b++) in_xfer(8'(b), b % 4);

    // R4 and R9: second strobe fall while a byte is held; mode request while busy
    @(negedge clk);
    pin_data_in = 8'hA5; dav_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(rx_data == 8'hA5, "R2 byte A5", rx_data, 8'hA5);
    dav_in = 1'b1;
    out_mode_req = 1'b1;
    repeat (4) @(negedge clk);
    pin_data_in = 8'h5A; dav_in = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(rx_data == 8'hA5, "R4 second fall ignored", rx_data, 8'hA5);
      chk(done == 1'b0, "R4 no done on ignored fall", done, 0);
      chk(pin_oe == 1'b0, "R9 mode held while busy", pin_oe, 0);
    end
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    repeat (4) @(negedge clk);
    chk(rdy_out == 1'b0, "R4 rdy low while strobe low", rdy_out, 0);
    chk(pin_oe == 1'b0, "R9 mode held while strobe low", pin_oe, 0);
    dav_in = 1'b1;
    repeat (5) @(negedge clk);
    chk(rx_valid == 1'b0, "R4 second byte never captured", rx_valid, 0);
    chk(pin_oe == 1'b1, "R9 mode switched when idle", pin_oe, 1);
    chk(rdy_out == 1'b1, "R9 rdy high in send mode", rdy_out, 1);

    // R9: strobe from peripheral ignored in send mode
    dav_in = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(rx_valid == 1'b0, "R9 dav_in ignored", rx_valid, 0);
      chk(rdy_out == 1'b1, "R9 rdy_out held high", rdy_out, 1);
    end
    dav_in = 1'b1;
    repeat (4) @(negedge clk);

    for (int b = 0; b < 256; b++) out_xfer(8'(255 - b), b % 3);

    out_mode_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(pin_oe == 1'b0, "R9 back to receive", pin_oe, 0);
    chk(dav_out == 1'b1, "R9 dav_out high in receive", dav_out, 1);
    in_xfer(8'h3C, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule